// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Block

This block is a calendar clock that software reaches through two byte ports. A write to the index port picks one register. A read strobe on the data port then returns the selected time field or a fixed control value. The block counts seconds, minutes, hours, weekday, day of month, month and year. A one-second tick enable advances the count, and the day of month rolls over at the end of each month, with leap years handled.

The year is held as an offset: years since 1900, minus 52. The first control register returns a constant pattern plus an update-in-progress bit. That bit flips on every read of the register and does not follow real update timing. The second control register always returns the same fixed mode byte. The third control register always returns zero.

A separate 1024 Hz tick enable drives a periodic interrupt. The interrupt stays asserted until software pulses the clear input. Reading the fourth control register, reading an unmapped index, or writing to the data port raises a one-cycle access error.

Top module: `rtc_index_regs`

## Requirements
- R1: A write to the index port (wrSel=0) selects a register. Read data from a rdEn strobe appears on rdData one cycle later. Index map: 0 seconds, 2 minutes, 4 hours, 6 weekday, 7 day of month, 8 month, 9 year, 10 control A, 11 control B, 12 control C, 13 control D.
- R2: After reset, and with default parameters, the time is 00:00:00 on Sunday (weekday 0), day 1 of month 1. The year reads 54.
- R3: Control A reads as {uip, 7'h26}. uip is 1 after reset and flips after each read of control A. Reads of other registers leave it unchanged.
- R4: Control B always reads 8'h46. Control C always reads 8'h00.
- R5: A read of index 13 or of any unmapped index returns 8'h00 and pulses accessErr for one cycle. A read of a mapped index leaves accessErr low.
- R6: A write to the data port (wrSel=1) pulses accessErr. It changes neither the time nor the selected index.
- R7: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R8: At midnight the weekday wraps from 6 to 0. The day of month wraps to 1 after the month's last day, which advances the month. The month wraps from 12 to 1, which increments the year.
- R9: February has 29 days when the stored year offset is divisible by 4, and 28 days otherwise.
- R10: A periodic tick while irq is low sets irq on the next cycle. irq then stays high through further ticks.
- R11: A pulse on irqClr drops irq on the next cycle, even when a periodic tick arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-second advance enable |
| periodicTick | input | 1 | 1024 Hz periodic interrupt enable |
| wrEn | input | 1 | Byte write strobe |
| wrSel | input | 1 | Write target: 0 index port, 1 data port |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Data port read strobe |
| irqClr | input | 1 | Clears the periodic interrupt |
| rdData | output | 8 | Registered read data |
| irq | output | 1 | Periodic interrupt, held until cleared |
| accessErr | output | 1 | One-cycle pulse on an unsupported access |

## Verification
Every result of this block passes through exactly one register. Read data, the update-in-progress flip, accessErr and irq all change at the first clock edge after their strobe. A time field read after a tick therefore shows the new value once that edge has passed. The bench drives inputs at falling edges and samples at the falling edge right after the capturing rising edge, so each check lands on the cycle the value is due. The one-cycle pulse of accessErr is checked in that same sample, and its return to low is checked one cycle later.

// File: rtl/rtc_index_pkg.sv
package rtc_index_pkg;
  localparam int unsigned DATA_W = 8;

  // Register indices: software depends on these positions.
  localparam logic [DATA_W-1:0] IDX_SEC  = 8'd0;
  localparam logic [DATA_W-1:0] IDX_MIN  = 8'd2;
  localparam logic [DATA_W-1:0] IDX_HOUR = 8'd4;
  localparam logic [DATA_W-1:0] IDX_DOW  = 8'd6;
  localparam logic [DATA_W-1:0] IDX_DOM  = 8'd7;
  localparam logic [DATA_W-1:0] IDX_MON  = 8'd8;
  localparam logic [DATA_W-1:0] IDX_YEAR = 8'd9;
  localparam logic [DATA_W-1:0] IDX_CTLA = 8'd10;
  localparam logic [DATA_W-1:0] IDX_CTLB = 8'd11;
  localparam logic [DATA_W-1:0] IDX_CTLC = 8'd12;

  localparam logic [6:0]        CTLA_LOW = 7'h26;
  localparam logic [DATA_W-1:0] CTLB_VAL = 8'h46;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              advance;
    logic              rdFire;
    logic [DATA_W-1:0] rdIdx;
    logic              uipBit;
  } rtc_strobe_t;

  // Current time as held by the datapath.
  typedef struct packed {
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] min;
    logic [DATA_W-1:0] hour;
    logic [DATA_W-1:0] dow;
    logic [DATA_W-1:0] dom;
    logic [DATA_W-1:0] mon;
    logic [DATA_W-1:0] yearOff;
  } rtc_time_t;
endpackage

// File: rtl/rtc_index_ctrl.sv
module rtc_index_ctrl
  import rtc_index_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              periodicTick,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              irqClr,
  output rtc_strobe_t       strb,
  output logic              irq,
  output logic              accessErr
);
  logic [DATA_W-1:0] idxQ;
  logic              uipQ;
  logic              idxKnown;

  always_comb begin
    case (idxQ)
      IDX_SEC, IDX_MIN, IDX_HOUR, IDX_DOW, IDX_DOM, IDX_MON, IDX_YEAR,
      IDX_CTLA, IDX_CTLB, IDX_CTLC: idxKnown = 1'b1;
      default:                      idxKnown = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ      <= '0;
      uipQ      <= 1'b1;
      irq       <= 1'b0;
      accessErr <= 1'b0;
    end else begin
      if (wrEn && !wrSel) idxQ <= wrData;
      if (rdEn && idxQ == IDX_CTLA) uipQ <= ~uipQ;
      accessErr <= (wrEn && wrSel) || (rdEn && !idxKnown);
      // Clear has priority over a new periodic tick.
      if (irqClr)            irq <= 1'b0;
      else if (periodicTick) irq <= 1'b1;
    end
  end

  always_comb begin
    strb.advance = secTick;
    strb.rdFire  = rdEn;
    strb.rdIdx   = idxQ;
    strb.uipBit  = uipQ;
  end
endmodule

// File: rtl/rtc_index_time.sv
module rtc_index_time
  import rtc_index_pkg::*;
#(
  parameter int unsigned INIT_SEC  = 0,
  parameter int unsigned INIT_MIN  = 0,
  parameter int unsigned INIT_HOUR = 0,
  parameter int unsigned INIT_DOW  = 0,
  parameter int unsigned INIT_DOM  = 1,
  parameter int unsigned INIT_MON  = 1,
  parameter int unsigned INIT_YEAR = 54
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtc_strobe_t       strb,
  output logic [DATA_W-1:0] rdData,
  output rtc_time_t         snap
);
  localparam logic [DATA_W-1:0] SEC_LAST  = 8'd59;
  localparam logic [DATA_W-1:0] HOUR_LAST = 8'd23;
  localparam logic [DATA_W-1:0] DOW_LAST  = 8'd6;
  localparam logic [DATA_W-1:0] MON_LAST  = 8'd12;

  rtc_time_t         t;
  logic              leapYear;
  logic [DATA_W-1:0] monLen;
  logic              lastSec, lastMin, lastHour, lastDom, lastMon;
  logic [DATA_W-1:0] muxVal;

  function automatic logic [DATA_W-1:0] monthLength(input logic [DATA_W-1:0] m,
                                                    input logic leap);
    case (m)
      8'd2:                    monthLength = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: monthLength = 8'd30;
      default:                 monthLength = 8'd31;
    endcase
  endfunction

  // The offset base (1952) is itself a multiple of four.
  assign leapYear = (t.yearOff[1:0] == 2'b00);
  assign monLen   = monthLength(t.mon, leapYear);
  assign lastSec  = (t.sec == SEC_LAST);
  assign lastMin  = (t.min == SEC_LAST);
  assign lastHour = (t.hour == HOUR_LAST);
  assign lastDom  = (t.dom == monLen);
  assign lastMon  = (t.mon == MON_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      t.sec     <= 8'(INIT_SEC);
      t.min     <= 8'(INIT_MIN);
      t.hour    <= 8'(INIT_HOUR);
      t.dow     <= 8'(INIT_DOW);
      t.dom     <= 8'(INIT_DOM);
      t.mon     <= 8'(INIT_MON);
      t.yearOff <= 8'(INIT_YEAR);
    end else if (strb.advance) begin
      t.sec <= lastSec ? '0 : t.sec + 8'd1;
      if (lastSec) begin
        t.min <= lastMin ? '0 : t.min + 8'd1;
        if (lastMin) begin
          t.hour <= lastHour ? '0 : t.hour + 8'd1;
          if (lastHour) begin
            t.dow <= (t.dow == DOW_LAST) ? '0 : t.dow + 8'd1;
            t.dom <= lastDom ? 8'd1 : t.dom + 8'd1;
            if (lastDom) begin
              t.mon <= lastMon ? 8'd1 : t.mon + 8'd1;
              if (lastMon) t.yearOff <= t.yearOff + 8'd1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (strb.rdIdx)
      IDX_SEC:  muxVal = t.sec;
      IDX_MIN:  muxVal = t.min;
      IDX_HOUR: muxVal = t.hour;
      IDX_DOW:  muxVal = t.dow;
      IDX_DOM:  muxVal = t.dom;
      IDX_MON:  muxVal = t.mon;
      IDX_YEAR: muxVal = t.yearOff;
      IDX_CTLA: muxVal = {strb.uipBit, CTLA_LOW};
      IDX_CTLB: muxVal = CTLB_VAL;
      default:  muxVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdFire) rdData <= muxVal;
  end

  assign snap = t;
endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
  import rtc_index_pkg::*;
#(
  parameter int unsigned INIT_SEC  = 0,
  parameter int unsigned INIT_MIN  = 0,
  parameter int unsigned INIT_HOUR = 0,
  parameter int unsigned INIT_DOW  = 0,
  parameter int unsigned INIT_DOM  = 1,
  parameter int unsigned INIT_MON  = 1,
  parameter int unsigned INIT_YEAR = 54
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       periodicTick,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  input  logic       irqClr,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       accessErr
);
  rtc_strobe_t strb;
  rtc_time_t   snap;

  rtc_index_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .periodicTick(periodicTick),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdEn(rdEn),
    .irqClr(irqClr), .strb(strb), .irq(irq), .accessErr(accessErr)
  );

  rtc_index_time #(
    .INIT_SEC(INIT_SEC), .INIT_MIN(INIT_MIN), .INIT_HOUR(INIT_HOUR),
    .INIT_DOW(INIT_DOW), .INIT_DOM(INIT_DOM), .INIT_MON(INIT_MON),
    .INIT_YEAR(INIT_YEAR)
  ) u_time (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData), .snap(snap)
  );
endmodule

// File: rtl/rtc_index_checker.sv
module rtc_index_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       wrSel,
  input logic       rdEn,
  input logic       periodicTick,
  input logic       irqClr,
  input logic       irq,
  input logic       accessErr,
  input logic [7:0] rdIdx,
  input logic [7:0] rdData,
  input logic [7:0] secNow,
  input logic [7:0] minNow,
  input logic [7:0] hourNow,
  input logic [7:0] domNow,
  input logic [7:0] monNow
);
  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (periodicTick && !irqClr) |=> irq);
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);
  p_irq_clr_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqClr |=> !irq);
  p_data_wr_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> accessErr);
  p_known_ok_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdIdx == 8'd0 && !(wrEn && wrSel)) |=> !accessErr);
  p_ctlb_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdIdx == 8'd11) |=> rdData == 8'h46);
  p_ctla_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdIdx == 8'd10) |=> rdData[6:0] == 7'h26);
  p_time_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    secNow < 8'd60 && minNow < 8'd60 && hourNow < 8'd24);
  p_date_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    domNow >= 8'd1 && domNow <= 8'd31 && monNow >= 8'd1 && monNow <= 8'd12);
endmodule

bind rtc_index_regs rtc_index_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .rdEn(rdEn),
  .periodicTick(periodicTick), .irqClr(irqClr), .irq(irq),
  .accessErr(accessErr), .rdIdx(strb.rdIdx), .rdData(rdData),
  .secNow(snap.sec), .minNow(snap.min), .hourNow(snap.hour),
  .domNow(snap.dom), .monNow(snap.mon)
);

// File: tb/test_rtc_index_regs.sv
`timescale 1ns/1ps
module test_rtc_index_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0, periodicTick = 1'b0, wrEn = 1'b0, wrSel = 1'b0;
  logic rdEn = 1'b0, irqClr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdA, rdB, rdC, rdD;
  logic irqA, irqB, irqC, irqD, errA, errB, errC, errD;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  // Default start: 2006-01-01 00:00:00 Sunday.
  rtc_index_regs i_rtc_index_regs (
    .clk(clk), .rstN(rstN), .secTick(secTick), .periodicTick(periodicTick),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdEn(rdEn), .irqClr(irqClr),
    .rdData(rdA), .irq(irqA), .accessErr(errA));
  // 2007-12-31 23:59:58 Monday.
  rtc_index_regs #(.INIT_SEC(58), .INIT_MIN(59), .INIT_HOUR(23), .INIT_DOW(1),
    .INIT_DOM(31), .INIT_MON(12), .INIT_YEAR(55)) i_rtc_index_regs_yr (
    .clk(clk), .rstN(rstN), .secTick(secTick), .periodicTick(periodicTick),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdEn(rdEn), .irqClr(irqClr),
    .rdData(rdB), .irq(irqB), .accessErr(errB));
  // 2007-02-28 23:59:59 Wednesday.
  rtc_index_regs #(.INIT_SEC(59), .INIT_MIN(59), .INIT_HOUR(23), .INIT_DOW(3),
    .INIT_DOM(28), .INIT_MON(2), .INIT_YEAR(55)) i_rtc_index_regs_feb (
    .clk(clk), .rstN(rstN), .secTick(secTick), .periodicTick(periodicTick),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdEn(rdEn), .irqClr(irqClr),
    .rdData(rdC), .irq(irqC), .accessErr(errC));
  // 2008-02-28 23:59:59 Thursday.
  rtc_index_regs #(.INIT_SEC(59), .INIT_MIN(59), .INIT_HOUR(23), .INIT_DOW(4),
    .INIT_DOM(28), .INIT_MON(2), .INIT_YEAR(56)) i_rtc_index_regs_leap (
    .clk(clk), .rstN(rstN), .secTick(secTick), .periodicTick(periodicTick),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdEn(rdEn), .irqClr(irqClr),
    .rdData(rdD), .irq(irqD), .accessErr(errD));

  // {requirement number, index, expected} for the default instance after reset.
  localparam logic [23:0] RESET_VEC [10] = '{
    {8'd2, 8'd0,  8'd0},  {8'd2, 8'd2,  8'd0},  {8'd2, 8'd4,  8'd0},
    {8'd2, 8'd6,  8'd0},  {8'd2, 8'd7,  8'd1},  {8'd2, 8'd8,  8'd1},
    {8'd2, 8'd9,  8'd54}, {8'd4, 8'd11, 8'h46}, {8'd4, 8'd12, 8'h00},
    {8'd1, 8'd4,  8'd0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic selIdx(input logic [7:0] idx);
    @(negedge clk); wrEn = 1'b1; wrSel = 1'b0; wrData = idx;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic readCur();
    rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] idx);
    selIdx(idx);
    readCur();
  endtask

  task automatic ticks(input int n);
    @(negedge clk); secTick = 1'b1;
    repeat (n) @(negedge clk);
    secTick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 rdData reset", rdA, 8'h00);
    chk("R10 irq reset", {7'd0, irqA}, 8'd0);
    chk("R5 err reset", {7'd0, errA}, 8'd0);
    rstN = 1'b1;

    // Table walk: R1 selection, R2 reset time, R4 fixed registers.
    for (int i = 0; i < 10; i++) begin
      readReg(RESET_VEC[i][15:8]);
      chk($sformatf("R%0d table idx %0d", RESET_VEC[i][23:16], RESET_VEC[i][15:8]),
          rdA, RESET_VEC[i][7:0]);
      chk("R5 no err on mapped read", {7'd0, errA}, 8'd0);
    end

    // R3: update-in-progress bit flips per control A read only.
    readReg(8'd10); chk("R3 first A read", rdA, 8'hA6);
    readCur();      chk("R3 second A read", rdA, 8'h26);
    readReg(8'd0);  chk("R1 sec between", rdA, 8'd0);
    readReg(8'd10); chk("R3 A after other read", rdA, 8'hA6);

    // R5: control D and an unmapped index.
    readReg(8'd13);
    chk("R5 D data", rdA, 8'h00);
    chk("R5 D err", {7'd0, errA}, 8'd1);
    @(negedge clk);
    chk("R5 err one cycle", {7'd0, errA}, 8'd0);
    readReg(8'h30);
    chk("R5 unmapped err", {7'd0, errA}, 8'd1);

    // R6: data-port write flagged, index and time untouched.
    selIdx(8'd7);
    @(negedge clk); wrEn = 1'b1; wrSel = 1'b1; wrData = 8'h99;
    @(negedge clk); wrEn = 1'b0; wrSel = 1'b0;
    chk("R6 data write err", {7'd0, errA}, 8'd1);
    readCur();
    chk("R6 index kept, dom unchanged", rdA, 8'd1);
    chk("R6 no err on following read", {7'd0, errA}, 8'd0);

    // One tick: month ends.
    ticks(1);
    readReg(8'd0); chk("R7 sec advance", rdA, 8'd1);
    readReg(8'd8); chk("R8 nonleap Feb -> Mar", rdC, 8'd3);
    readReg(8'd7); chk("R9 nonleap dom", rdC, 8'd1);
                   chk("R9 leap dom 29", rdD, 8'd29);
    readReg(8'd6); chk("R8 dow Wed->Thu", rdC, 8'd4);
                   chk("R9 leap dow Fri", rdD, 8'd5);
    readReg(8'd8); chk("R9 leap still Feb", rdD, 8'd2);
    readReg(8'd9); chk("R8 year before roll", rdB, 8'd55);

    // Second tick: year end.
    ticks(1);
    readReg(8'd9); chk("R8 year increments", rdB, 8'd56);
    readReg(8'd8); chk("R8 month 12->1", rdB, 8'd1);
    readReg(8'd7); chk("R8 dom 31->1", rdB, 8'd1);
    readReg(8'd6); chk("R8 dow Mon->Tue", rdB, 8'd2);
    readReg(8'd4); chk("R7 hour 23->0", rdB, 8'd0);
    readReg(8'd2); chk("R7 min 59->0", rdB, 8'd0);
    readReg(8'd0); chk("R7 sec 59->0", rdB, 8'd0);

    // 58 ticks: default instance reaches one minute.
    ticks(58);
    readReg(8'd0); chk("R7 sec wraps", rdA, 8'd0);
    readReg(8'd2); chk("R7 min carry", rdA, 8'd1);

    // Up to 86401 ticks total: leap instance reaches March 1.
    ticks(86341);
    readReg(8'd8); chk("R9 leap Feb -> Mar", rdD, 8'd3);
    readReg(8'd7); chk("R9 leap dom 1", rdD, 8'd1);
                   chk("R8 default next day", rdA, 8'd2);
    readReg(8'd6); chk("R9 leap dow Sat", rdD, 8'd6);
                   chk("R8 default dow Mon", rdA, 8'd1);
    readReg(8'd4); chk("R7 default hour wrap", rdA, 8'd0);
    readReg(8'd0); chk("R7 default sec", rdA, 8'd1);

    // R10 / R11: periodic interrupt.
    @(negedge clk); periodicTick = 1'b1;
    @(negedge clk); periodicTick = 1'b0;
    chk("R10 irq set", {7'd0, irqA}, 8'd1);
    @(negedge clk); periodicTick = 1'b1;
    @(negedge clk); periodicTick = 1'b0;
    chk("R10 irq held", {7'd0, irqA}, 8'd1);
    @(negedge clk);
    chk("R10 irq held idle", {7'd0, irqA}, 8'd1);
    irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
    chk("R11 irq cleared", {7'd0, irqA}, 8'd0);
    @(negedge clk); periodicTick = 1'b1;
    @(negedge clk); periodicTick = 1'b0;
    chk("R10 irq set again", {7'd0, irqA}, 8'd1);
    irqClr = 1'b1; periodicTick = 1'b1;
    @(negedge clk); irqClr = 1'b0; periodicTick = 1'b0;
    chk("R11 clear beats tick", {7'd0, irqA}, 8'd0);
    @(negedge clk);
    chk("R11 stays clear", {7'd0, irqA}, 8'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule